// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the per-pin state of a general-purpose parallel port: a direction register, an output value register and a read-inversion mask, together with a sampled view of the pin levels. A host writes and reads these registers one byte at a time. It uses a write strobe, a read strobe, a 2-bit register select and a data byte. From the stored state, the block drives an output enable and an output value for every pin buffer.

Pin levels enter through a synchroniser chain before anything reads them. The sampled levels are always taken from the pins, whatever the direction setting. A read of the input view is XORed with the inversion mask. A read of the output register returns the stored bits and not the pin levels. The serial bus front end and any change-detection logic sit outside this block.

Top module: `gpio_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, the direction register reads 8'hFF, the output register reads 8'hFF and the inversion mask reads 8'h00. In this state `pin_oe` is 8'h00 and `pin_out` is 8'h00.
- R2: The select encoding is 0 = input view, 1 = output register, 2 = inversion mask, 3 = direction register. When `wr_en` is high at a rising clock edge, `wr_data` is stored into the selected writable register. A read in the following cycle returns the stored value.
- R3: A write with `reg_sel` = 0 changes no state. `pin_oe`, `pin_out` and the read-back of selects 1, 2 and 3 are unchanged after it.
- R4: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). The new enable is visible in the cycle that follows the write edge.
- R5: For an output pin, the `pin_out` bit equals the matching output register bit. For an input pin, the `pin_out` bit is 0 whatever the output register holds.
- R6: A read of the output register returns the stored bits. The result does not depend on `pin_in` or on the direction setting.
- R7: A read with select 0 returns the pin levels sampled two rising edges earlier, XORed bitwise with the inversion mask (mask bit 1 inverts, 0 passes). This holds for every pin, including pins set as outputs.
- R8: While `rd_en` is low, `rd_data` is 8'h00. While `rd_en` is high, `rd_data` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; gates `rd_data` |
| reg_sel | input | 2 | Register select (0 input view, 1 output, 2 inversion, 3 direction) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Raw pin levels from the pad receivers |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin driven value |

## Verification
A corrupted direction or output bit appears on `pin_oe` or `pin_out` in the cycle after the offending write edge. It also appears in the read-back of select 1 or 3 on the very next read. A wrong inversion bit or a broken synchroniser stage shows in the select-0 read data. Because the pin path carries two edges of delay, that error is visible exactly two edges after the pin change. The sweeps therefore compare every output immediately after each write, and the input view only after those two edges.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_INPUT     = 2'd0,
      SEL_OUTPUT    = 2'd1,
      SEL_INVERT    = 2'd2,
      SEL_DIRECTION = 2'd3
   } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for a bus of independent pin levels.
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_field_reg.sv
// One host-writable register with a parameterised reset value.
module gpio_field_reg #(
   parameter int unsigned   W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST;
      end else if (we) begin
         q <= d;
      end
   end
endmodule

// File: rtl/gpio_rd_mux.sv
// Read-back multiplexer; the input view is XORed with the inversion mask.
module gpio_rd_mux #(
   parameter int unsigned W = 8
) (
   input  logic                                  rd_en,
   input  logic [gpio_regbank_pkg::SEL_W-1:0]    sel,
   input  logic [W-1:0]                          pins_sync,
   input  logic [W-1:0]                          out_q,
   input  logic [W-1:0]                          inv_q,
   input  logic [W-1:0]                          dir_q,
   output logic [W-1:0]                          rd_data
);
   import gpio_regbank_pkg::*;

   logic [W-1:0] sel_data;

   always_comb begin
      unique case (gpio_sel_e'(sel))
         SEL_INPUT:     sel_data = pins_sync ^ inv_q;
         SEL_OUTPUT:    sel_data = out_q;
         SEL_INVERT:    sel_data = inv_q;
         SEL_DIRECTION: sel_data = dir_q;
         default:       sel_data = '0;
      endcase
   end

   assign rd_data = rd_en ? sel_data : '0;
endmodule

// File: rtl/gpio_regbank.sv
// Per-pin GPIO register bank: direction, output value, read inversion.
module gpio_regbank #(
   parameter int unsigned        PIN_W       = 8,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [PIN_W-1:0]   DIR_RST     = '1,
   parameter logic [PIN_W-1:0]   OUT_RST     = '1,
   parameter logic [PIN_W-1:0]   INV_RST     = '0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic                                rd_en,
   input  logic [gpio_regbank_pkg::SEL_W-1:0]  reg_sel,
   input  logic [PIN_W-1:0]                    wr_data,
   output logic [PIN_W-1:0]                    rd_data,
   input  logic [PIN_W-1:0]                    pin_in,
   output logic [PIN_W-1:0]                    pin_oe,
   output logic [PIN_W-1:0]                    pin_out
);
   import gpio_regbank_pkg::*;

   generate
      if (PIN_W < 1) begin : g_bad_width
         $error("gpio_regbank: PIN_W must be at least 1");
      end
   endgenerate

   logic               we_out;
   logic               we_inv;
   logic               we_dir;
   logic [PIN_W-1:0]   out_q;
   logic [PIN_W-1:0]   inv_q;
   logic [PIN_W-1:0]   dir_q;
   logic [PIN_W-1:0]   pins_sync;

   // Writes to the input view decode to no enable at all.
   assign we_out = wr_en && (reg_sel == SEL_OUTPUT);
   assign we_inv = wr_en && (reg_sel == SEL_INVERT);
   assign we_dir = wr_en && (reg_sel == SEL_DIRECTION);

   gpio_field_reg #(.W(PIN_W), .RST(OUT_RST)) u_out_reg (
      .clk(clk), .rst_n(rst_n), .we(we_out), .d(wr_data), .q(out_q)
   );

   gpio_field_reg #(.W(PIN_W), .RST(INV_RST)) u_inv_reg (
      .clk(clk), .rst_n(rst_n), .we(we_inv), .d(wr_data), .q(inv_q)
   );

   gpio_field_reg #(.W(PIN_W), .RST(DIR_RST)) u_dir_reg (
      .clk(clk), .rst_n(rst_n), .we(we_dir), .d(wr_data), .q(dir_q)
   );

   gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
   );

   // Per-pin buffer control: an input pin neither drives nor shows its value.
   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_pin
         assign pin_oe[i]  = ~dir_q[i];
         assign pin_out[i] = dir_q[i] ? 1'b0 : out_q[i];
      end
   endgenerate

   gpio_rd_mux #(.W(PIN_W)) u_rd_mux (
      .rd_en(rd_en), .sel(reg_sel), .pins_sync(pins_sync),
      .out_q(out_q), .inv_q(inv_q), .dir_q(dir_q), .rd_data(rd_data)
   );
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int unsigned PIN_W = 8
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                wr_en,
   input logic                                rd_en,
   input logic [gpio_regbank_pkg::SEL_W-1:0]  reg_sel,
   input logic [PIN_W-1:0]                    wr_data,
   input logic [PIN_W-1:0]                    rd_data,
   input logic [PIN_W-1:0]                    pin_in,
   input logic [PIN_W-1:0]                    pin_oe,
   input logic [PIN_W-1:0]                    pin_out,
   input logic [PIN_W-1:0]                    inv_q
);
   logic [1:0] live_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_cnt_q <= '0;
      end else if (live_cnt_q != 2'd3) begin
         live_cnt_q <= live_cnt_q + 2'd1;
      end
   end

   // R1
   reset_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt_q == 2'd0) |-> (pin_oe == '0 && pin_out == '0));

   // R3
   input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt_q != 2'd0 && wr_en && reg_sel == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));

   // R4
   dir_sets_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd3) |=> (pin_oe == ~$past(wr_data)));

   // R5
   out_write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1) |=> ((pin_out & pin_oe) == ($past(wr_data) & pin_oe)));

   // R5
   idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   // R7
   input_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt_q >= 2'd2 && rd_en && reg_sel == 2'd0) |-> (rd_data == ($past(pin_in, 2) ^ inv_q)));

   // R8
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));
endmodule

bind gpio_regbank gpio_regbank_chk #(.PIN_W(PIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
   .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
   .pin_out(pin_out), .inv_q(inv_q)
);

// File: tb/gpio_regbank_bench.sv
`timescale 1ns/1ps
module gpio_regbank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] pin_in;
   logic [7:0] pin_oe;
   logic [7:0] pin_out;
   logic [7:0] ext_en = 8'h00;
   logic [7:0] ext_val = 8'h00;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // Pad model: driven pins show the driver, others an external level or a pull-up.
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ((ext_en & ext_val) | ~ext_en));

   gpio_regbank u_gpio_regbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; reg_sel = s;
      #2 v = rd_data;
      rd_en = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pin_oe, 8'h00);
      chk("R1 out in reset", pin_out, 8'h00);
      rst_n = 1'b1;
      rd(2'd1, v); chk("R1 output reg default", v, 8'hFF);
      rd(2'd2, v); chk("R1 invert default", v, 8'h00);
      rd(2'd3, v); chk("R1 direction default", v, 8'hFF);
      rd(2'd0, v); chk("R1 pulled-up input view", v, 8'hFF);
      chk("R1 oe after reset", pin_oe, 8'h00);

      // R8: read strobe low forces zero on every select
      for (int s = 0; s < 4; s++) begin
         @(negedge clk); rd_en = 1'b0; reg_sel = 2'(s);
         #2 chk("R8 idle read", rd_data, 8'h00);
      end

      // R2 / R6: output register write/readback sweep, all inputs, pins externally driven
      ext_en = 8'hFF;
      for (int d = 0; d < 256; d++) begin
         ext_val = ~8'(d);
         wr(2'd1, 8'(d));
         rd(2'd1, v); chk("R6 output readback", v, 8'(d));
         chk("R5 input pins not driven", pin_out, 8'h00);
      end

      // R4 / R5 / R7 / R6: direction sweep with fixed output value
      wr(2'd1, 8'h3C);
      for (int d = 0; d < 256; d++) begin
         ext_val = 8'(d) ^ 8'hA7;
         wr(2'd3, 8'(d));
         chk("R4 oe from direction", pin_oe, ~8'(d));
         chk("R5 drive value", pin_out, 8'h3C & ~8'(d));
         repeat (2) @(negedge clk);
         rd(2'd0, v); chk("R7 pins incl outputs", v, (~8'(d) & 8'h3C) | (8'(d) & (8'(d) ^ 8'hA7)));
         rd(2'd1, v); chk("R6 output read not pin", v, 8'h3C);
         rd(2'd3, v); chk("R2 direction readback", v, 8'(d));
      end

      // R7 / R2: inversion mask sweep, all pins inputs
      wr(2'd3, 8'hFF);
      ext_val = 8'hC3;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 256; m++) begin
         wr(2'd2, 8'(m));
         rd(2'd0, v); chk("R7 inverted input", v, 8'hC3 ^ 8'(m));
         rd(2'd2, v); chk("R2 invert readback", v, 8'(m));
      end
      wr(2'd2, 8'h00);

      // R7: two-edge synchroniser latency
      @(negedge clk);
      ext_val = 8'h96;
      @(negedge clk); rd_en = 1'b1; reg_sel = 2'd0;
      #2 chk("R7 one edge old value", rd_data, 8'hC3);
      @(negedge clk);
      #2 chk("R7 two edges new value", rd_data, 8'h96);
      rd_en = 1'b0;

      // R3: writes to the input view change nothing
      wr(2'd1, 8'h5A); wr(2'd2, 8'h0F); wr(2'd3, 8'hF0);
      for (int k = 0; k < 8; k++) begin
         wr(2'd0, 8'(k * 37 + 11));
         chk("R3 oe unchanged", pin_oe, 8'h0F);
         chk("R3 out unchanged", pin_out, 8'h0A);
         rd(2'd1, v); chk("R3 output reg kept", v, 8'h5A);
         rd(2'd2, v); chk("R3 invert kept", v, 8'h0F);
         rd(2'd3, v); chk("R3 direction kept", v, 8'hF0);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog all-R actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule